// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Burst Addressing

This block is a true dual-port synchronous memory. Each of its two ports has its own clock, reset, control and data pins. Either port may read or write any word in any cycle, and the other port works at the same time without waiting. Address, control and write data are captured on the rising edge of the port's clock. A write reaches the array on the port's next rising edge.

The address register of each port is also a burst counter. In any cycle it can be cleared to zero, loaded from the address pins, advanced by one, or held. When it advances it wraps from the top word back to word zero. During an advance the address pins are ignored, so a port can stream consecutive words after giving a single start address.

Each port has a static mode pin that picks the read path. In flow-through mode the data read at the registered address appears in the same cycle. In pipelined mode the data passes through one extra output register. Two chip selects of opposite polarity gate each port. When a port is deselected it does not write and drives no valid output. An asynchronous output enable forces the output invalid at once. A driven output is modelled as a valid flag plus data, and the data reads zero whenever the flag is low.

Top module: `burst_dpram`

## Requirements
- R1: The two ports work at the same time. A word written through one port can be read through the other. A read on one port returns correct data while the other port is writing different words in the same cycles.
- R2: A write command sampled at a rising edge is stored in the array at the port's next rising edge. A flow-through read of that word in the cycle between those two edges still returns the old value.
- R3: In flow-through mode (`pipe_x`=0), `rdata_x` shows the word at the address register from the edge that loaded it, with `rvalid_x` high.
- R4: In pipelined mode (`pipe_x`=1), the word appears one rising edge later than in flow-through mode.
- R5: A port is selected only when `cs_n_x`=0 and `cs_x`=1. A write sampled while the port is deselected changes nothing. In flow-through mode `rvalid_x` is low in the cycle after a deselected edge.
- R6: In pipelined mode, after a deselected edge the output stays invalid through the first selected edge. It becomes valid again only at the edge after that.
- R7: The counter controls are active low, with priority clear > load > advance. With all three high the counter holds.
- R8: `ctr_ld_n_x`=0 (without clear) loads the counter from `addr_x`.
- R9: `ctr_inc_n_x`=0 (without clear or load) advances the counter by one per edge and ignores `addr_x`.
- R10: The counter wraps from address 2^AW-1 to 0. This holds for both reads and writes.
- R11: `ctr_clr_n_x`=0 sets the counter to zero, whatever the other controls are.
- R12: `oe_n_x`=1 drives `rvalid_x` low and `rdata_x` to zero at once, with no clock edge. `oe_n_x`=0 restores the output.
- R13: While `rst_x` is high, `rvalid_x` is low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| pipe_a | input | 1 | Port A read path: 1 pipelined, 0 flow-through |
| cs_n_a | input | 1 | Port A select, active low |
| cs_a | input | 1 | Port A select, active high |
| we_a | input | 1 | Port A write command |
| oe_n_a | input | 1 | Port A output enable, active low, asynchronous |
| ctr_clr_n_a | input | 1 | Port A counter clear, active low |
| ctr_ld_n_a | input | 1 | Port A counter load, active low |
| ctr_inc_n_a | input | 1 | Port A counter advance, active low |
| addr_a | input | AW | Port A external address |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A read data, zero when not valid |
| rvalid_a | output | 1 | Port A output driven |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| pipe_b | input | 1 | Port B read path: 1 pipelined, 0 flow-through |
| cs_n_b | input | 1 | Port B select, active low |
| cs_b | input | 1 | Port B select, active high |
| we_b | input | 1 | Port B write command |
| oe_n_b | input | 1 | Port B output enable, active low, asynchronous |
| ctr_clr_n_b | input | 1 | Port B counter clear, active low |
| ctr_ld_n_b | input | 1 | Port B counter load, active low |
| ctr_inc_n_b | input | 1 | Port B counter advance, active low |
| addr_b | input | AW | Port B external address |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B read data, zero when not valid |
| rvalid_b | output | 1 | Port B output driven |

## Verification
The bench runs a 16-word instance and fills every word by burst. It then reads every word back, past the wrap, through the other port. A counter that does not wrap, or that takes the address pins during an advance, returns the wrong word. It reads in pipelined mode and checks the one-cycle shift, and it runs the reactivation sequence after a deselect. A design that skips the extra register, or that re-enables one cycle early, shows the wrong word or a valid flag that is high too soon. It also drives conflicting counter controls, writes while deselected, reads a word in the cycle after writing it, and toggles the output enable between edges. These catch a wrong priority, writes that leak through, early write commit and an output enable that waits for a clock edge.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_CLR  = 2'd3
  } ctr_op_e;

  // Active-low controls; clear wins over load, load wins over advance.
  function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n,
                                         input logic inc_n);
    if (!clr_n) return CTR_CLR;
    if (!ld_n)  return CTR_LOAD;
    if (!inc_n) return CTR_INC;
    return CTR_HOLD;
  endfunction

endpackage

// File: rtl/dpb_xor_bank.sv
module dpb_xor_bank #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr0,
  input  logic [AW-1:0] rd_addr1,
  output logic [DW-1:0] rd_data0,
  output logic [DW-1:0] rd_data1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data0 = mem[rd_addr0];
  assign rd_data1 = mem[rd_addr1];
endmodule

// File: rtl/dpb_burst_ctr.sv
module dpb_burst_ctr
  import dpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cnt
);
  ctr_op_e op;

  assign op = ctr_decode(clr_n, ld_n, inc_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case (op)
        CTR_CLR:  cnt <= '0;
        CTR_LOAD: cnt <= addr_in;
        CTR_INC:  cnt <= cnt + AW'(1);
        default:  cnt <= cnt;
      endcase
    end
  end

  // R11
  ctr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> cnt == '0);

  // R8
  ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |=> cnt == $past(addr_in));

  // R9 R10
  ctr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !inc_n) |=> cnt == $past(cnt) + AW'(1));

  // R7
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && inc_n) |=> $stable(cnt));
endmodule

// File: rtl/dpb_port_side.sv
module dpb_port_side #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          we,
  input  logic          oe_n,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_rd,
  output logic [AW-1:0] cnt,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          sel_q;
  logic          we_q;
  logic [DW-1:0] wd_q;
  logic          sel_p;
  logic [DW-1:0] dout_q;
  logic          stage_sel;
  logic [DW-1:0] stage_dat;

  dpb_burst_ctr #(.AW(AW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .inc_n   (inc_n),
    .addr_in (addr),
    .cnt     (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      sel_p  <= 1'b0;
      dout_q <= '0;
    end else begin
      sel_q  <= ~cs_n & cs;
      we_q   <= we;
      wd_q   <= wdata;
      sel_p  <= sel_q;
      dout_q <= mem_rd;
    end
  end

  assign wr_en   = sel_q & we_q;
  assign wr_data = wd_q;

  always_comb begin
    if (pipe) begin
      stage_sel = sel_p;
      stage_dat = dout_q;
    end else begin
      stage_sel = sel_q;
      stage_dat = mem_rd;
    end
  end

  assign rvalid = stage_sel & ~oe_n;
  assign rdata  = rvalid ? stage_dat : '0;

  // R5
  flow_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe && (cs_n || !cs)) |=> (pipe || !rvalid));

  // R6
  pipe_reactivate_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe && !sel_q) |=> (!pipe || !rvalid));
endmodule

// File: rtl/burst_dpram.sv
module burst_dpram #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          pipe_a,
  input  logic          cs_n_a,
  input  logic          cs_a,
  input  logic          we_a,
  input  logic          oe_n_a,
  input  logic          ctr_clr_n_a,
  input  logic          ctr_ld_n_a,
  input  logic          ctr_inc_n_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  output logic          rvalid_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          pipe_b,
  input  logic          cs_n_b,
  input  logic          cs_b,
  input  logic          we_b,
  input  logic          oe_n_b,
  input  logic          ctr_clr_n_b,
  input  logic          ctr_ld_n_b,
  input  logic          ctr_inc_n_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b,
  output logic          rvalid_b
);
  localparam int NP = 2;

  logic          clk_v  [NP];
  logic [AW-1:0] cnt_v  [NP];
  logic          wen_v  [NP];
  logic [DW-1:0] wd_v   [NP];
  logic [DW-1:0] mrd_v  [NP];
  logic [DW-1:0] rd     [NP][NP];

  assign clk_v[0] = clk_a;
  assign clk_v[1] = clk_b;

  dpb_port_side #(.AW(AW), .DW(DW)) u_port_a (
    .clk (clk_a), .rst (rst_a), .pipe (pipe_a), .cs_n (cs_n_a), .cs (cs_a),
    .we (we_a), .oe_n (oe_n_a), .clr_n (ctr_clr_n_a), .ld_n (ctr_ld_n_a),
    .inc_n (ctr_inc_n_a), .addr (addr_a), .wdata (wdata_a), .mem_rd (mrd_v[0]),
    .cnt (cnt_v[0]), .wr_en (wen_v[0]), .wr_data (wd_v[0]),
    .rdata (rdata_a), .rvalid (rvalid_a)
  );

  dpb_port_side #(.AW(AW), .DW(DW)) u_port_b (
    .clk (clk_b), .rst (rst_b), .pipe (pipe_b), .cs_n (cs_n_b), .cs (cs_b),
    .we (we_b), .oe_n (oe_n_b), .clr_n (ctr_clr_n_b), .ld_n (ctr_ld_n_b),
    .inc_n (ctr_inc_n_b), .addr (addr_b), .wdata (wdata_b), .mem_rd (mrd_v[1]),
    .cnt (cnt_v[1]), .wr_en (wen_v[1]), .wr_data (wd_v[1]),
    .rdata (rdata_b), .rvalid (rvalid_b)
  );

  // Bank p is written only by port p; a word's value is the XOR of both banks.
  for (genvar p = 0; p < NP; p++) begin : g_bank
    logic [DW-1:0] bank_wd;
    assign bank_wd = wd_v[p] ^ rd[NP-1-p][p];

    dpb_xor_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk      (clk_v[p]),
      .wr_en    (wen_v[p]),
      .wr_addr  (cnt_v[p]),
      .wr_data  (bank_wd),
      .rd_addr0 (cnt_v[0]),
      .rd_addr1 (cnt_v[1]),
      .rd_data0 (rd[p][0]),
      .rd_data1 (rd[p][1])
    );
  end

  for (genvar q = 0; q < NP; q++) begin : g_merge
    assign mrd_v[q] = rd[0][q] ^ rd[1][q];
  end
endmodule

// File: tb/burst_dpram_bench.sv
module burst_dpram_bench;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic pipe_a, cs_n_a, cs_a, we_a, oe_n_a, clr_n_a, ld_n_a, inc_n_a;
  logic pipe_b, cs_n_b, cs_b, we_b, oe_n_b, clr_n_b, ld_n_b, inc_n_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW-1:0] wdata_a, wdata_b, rdata_a, rdata_b;
  logic rvalid_a, rvalid_b;

  int n_cmp = 0;
  int n_bad = 0;

  burst_dpram #(.AW(AW), .DW(DW)) u_burst_dpram (
    .clk_a (clk), .rst_a (rst), .pipe_a (pipe_a), .cs_n_a (cs_n_a), .cs_a (cs_a),
    .we_a (we_a), .oe_n_a (oe_n_a), .ctr_clr_n_a (clr_n_a), .ctr_ld_n_a (ld_n_a),
    .ctr_inc_n_a (inc_n_a), .addr_a (addr_a), .wdata_a (wdata_a),
    .rdata_a (rdata_a), .rvalid_a (rvalid_a),
    .clk_b (clk), .rst_b (rst), .pipe_b (pipe_b), .cs_n_b (cs_n_b), .cs_b (cs_b),
    .we_b (we_b), .oe_n_b (oe_n_b), .ctr_clr_n_b (clr_n_b), .ctr_ld_n_b (ld_n_b),
    .ctr_inc_n_b (inc_n_b), .addr_b (addr_b), .wdata_b (wdata_b),
    .rdata_b (rdata_b), .rvalid_b (rvalid_b)
  );

  function automatic logic [DW-1:0] f_pat(int i);
    return DW'((i * 37 + 5) % 512);
  endfunction

  function automatic logic [DW-1:0] h_pat(int i);
    return DW'((i * 53 + 100) % 512);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pa(logic c, logic l, logic i, logic w, int ad, logic [DW-1:0] d);
    clr_n_a = c; ld_n_a = l; inc_n_a = i; we_a = w; addr_a = AW'(ad); wdata_a = d;
  endtask

  task automatic pb(logic c, logic l, logic i, logic w, int ad, logic [DW-1:0] d);
    clr_n_b = c; ld_n_b = l; inc_n_b = i; we_b = w; addr_b = AW'(ad); wdata_b = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    pipe_a = 0; cs_n_a = 0; cs_a = 1; oe_n_a = 0;
    pipe_b = 0; cs_n_b = 0; cs_b = 1; oe_n_b = 0;
    pa(1, 1, 1, 0, 0, 0);
    pb(1, 1, 1, 0, 0, 0);
    repeat (3) tick();
    // R13 reset state
    chk("R13", DW'(rvalid_a), 0);
    chk("R13", DW'(rvalid_b), 0);
    rst = 1'b0;

    // R8 R9: burst fill through port A, address pins carry junk during advance
    for (int i = 0; i < N; i++) begin
      if (i == 0) pa(1, 0, 1, 1, 0, f_pat(0));
      else        pa(1, 1, 0, 1, (i * 7) % N, f_pat(i));
      tick();
    end
    pa(1, 1, 1, 0, 0, 0);
    tick();

    // R1 R9 R10: flow read of every word through port B, one step past the top
    for (int i = 0; i <= N; i++) begin
      if (i == 0) pb(1, 0, 1, 0, 0, 0);
      else        pb(1, 1, 0, 0, (i * 5) % N, 0);
      tick();
      chk(i == N ? "R10" : "R1", rdata_b, f_pat(i % N));
      chk("R3", DW'(rvalid_b), 1);
    end
    pb(1, 1, 1, 0, 0, 0);

    // R4: pipelined read on port A, data one edge later
    pipe_a = 1;
    for (int i = 0; i <= N; i++) begin
      pa(1, 0, 1, 0, i % N, 0);
      tick();
      if (i > 0) begin
        chk("R4", rdata_a, f_pat(i - 1));
        chk("R4", DW'(rvalid_a), 1);
      end
    end
    pipe_a = 0;

    // R1: A writes words 0..7 while B reads words 8..15 in the same cycles
    for (int i = 0; i < 8; i++) begin
      if (i == 0) begin
        pa(1, 0, 1, 1, 0, h_pat(0));
        pb(1, 0, 1, 0, 8, 0);
      end else begin
        pa(1, 1, 0, 1, 0, h_pat(i));
        pb(1, 1, 0, 0, 8, 0);
      end
      tick();
      chk("R1", rdata_b, f_pat(8 + i));
    end
    pa(1, 1, 1, 0, 0, 0);
    pb(1, 1, 1, 0, 0, 0);
    tick();
    for (int i = 0; i < 8; i++) begin
      pb(1, 0, 1, 0, i, 0);
      tick();
      chk("R1", rdata_b, h_pat(i));
    end

    // R2: same-port write then read
    pa(1, 0, 1, 1, 6, 9'h0AA);
    tick();
    chk("R2", rdata_a, h_pat(6));
    pa(1, 0, 1, 0, 6, 0);
    tick();
    chk("R2", rdata_a, 9'h0AA);

    // R5: writes while deselected by either select pin
    cs_n_b = 1;
    pb(1, 0, 1, 1, 3, 9'h1FF);
    tick();
    chk("R5", DW'(rvalid_b), 0);
    cs_n_b = 0; cs_b = 0;
    pb(1, 0, 1, 1, 4, 9'h1FE);
    tick();
    chk("R5", DW'(rvalid_b), 0);
    cs_b = 1;
    pb(1, 0, 1, 0, 3, 0);
    tick();
    chk("R5", rdata_b, h_pat(3));
    pb(1, 0, 1, 0, 4, 0);
    tick();
    chk("R5", rdata_b, h_pat(4));

    // R6: pipelined reactivation on port A
    pipe_a = 1;
    pa(1, 0, 1, 0, 2, 0);
    tick();
    tick();
    cs_n_a = 1;
    tick();
    cs_n_a = 0;
    tick();
    chk("R6", DW'(rvalid_a), 0);
    tick();
    chk("R6", DW'(rvalid_a), 1);
    chk("R6", rdata_a, h_pat(2));
    pipe_a = 0;

    // R3: flow-through reactivation is immediate on port B
    cs_n_b = 1;
    tick();
    chk("R3", DW'(rvalid_b), 0);
    cs_n_b = 0;
    tick();
    chk("R3", DW'(rvalid_b), 1);

    // R12: asynchronous output enable on port A
    pa(1, 0, 1, 0, 2, 0);
    tick();
    chk("R12", DW'(rvalid_a), 1);
    oe_n_a = 1;
    #2;
    chk("R12", DW'(rvalid_a), 0);
    chk("R12", rdata_a, 0);
    oe_n_a = 0;
    #2;
    chk("R12", DW'(rvalid_a), 1);
    chk("R12", rdata_a, h_pat(2));

    // R7 R8 R9 R11: counter priority on port B
    pb(1, 0, 1, 0, 9, 0);
    tick();
    chk("R8", rdata_b, f_pat(9));
    pb(0, 0, 0, 0, 5, 0);
    tick();
    chk("R11", rdata_b, h_pat(0));
    pb(1, 0, 0, 0, 12, 0);
    tick();
    chk("R7", rdata_b, f_pat(12));
    pb(1, 1, 0, 0, 2, 0);
    tick();
    chk("R9", rdata_b, f_pat(13));
    pb(1, 1, 1, 0, 2, 0);
    tick();
    chk("R7", rdata_b, f_pat(13));

    // R10: write burst across the wrap on port A
    pa(1, 0, 1, 1, N - 1, 9'h155);
    tick();
    pa(1, 1, 0, 1, 3, 9'h0CC);
    tick();
    pa(1, 1, 1, 0, 0, 0);
    tick();
    pb(1, 0, 1, 0, N - 1, 0);
    tick();
    chk("R10", rdata_b, 9'h155);
    pb(1, 0, 1, 0, 0, 0);
    tick();
    chk("R10", rdata_b, 9'h0CC);

    summary();
    $finish;
  end
endmodule